// File: doc/BRIEF.md
# Programmable Binary-Divider Timer

This block is a synchronous timer built around a sixteen-stage binary counter. It runs on a single-cycle tick enable that stands in for an external or RC-derived time base. A two-bit stage select picks which counter stage drives the output, so the division ratio is 2^8, 2^10, 2^13 or 2^16. The select codes do not follow the size of the ratio.

In repeat mode the output is a square wave with a period of 2^n ticks. In one-shot mode the output changes level once, 2^(n-1) ticks after a restart, and then holds that level. A phase input sets the level the output takes after a restart, so the output can run inverted.

A restart comes from a synchronous clear or from a single-cycle power-on request. The power-on request can be masked by a separate blocking input. While a restart is in effect, a run flag goes low so that the time base can be stopped.

Top module: `prog_divtimer`

## Requirements
- R1: In the cycle after a restart, `tmr_o` equals `invert_i` as sampled in the restart cycle, and the counter and the one-shot hold state are cleared.
- R2: `run_o` is 0 in any cycle where `clear_i` is 1, or where `por_req_i` is 1 and `por_block_i` is 0. Otherwise it is 1.
- R3: The counter advances by one only on a clock edge where `tick_i` is 1. With `tick_i` at 0 the count and the output do not change.
- R4: The stage count n is decoded from `sel_i` (bit 1, bit 0) as follows: 00 gives 13, 01 gives 8, 10 gives 10 and 11 gives 16. The output tap is counter bit n-1.
- R5: With `mode_i` at 1, `tmr_o` equals counter bit n-1 XOR `invert_i`. It is therefore a square wave with a period of 2^n ticks.
- R6: With `mode_i` at 0, `tmr_o` changes once, when the count first reaches 2^(n-1) after a restart. It then holds that level while the counter keeps running, until the next restart or the next rising edge of `mode_i`.
- R7: A rising edge of `mode_i` (1 now, 0 in the previous cycle) clears the one-shot hold state.
- R8: `invert_i` at 1 gives the complement of the output produced with `invert_i` at 0.
- R9: A power-on request restarts the block exactly as `clear_i` does, and only when `por_block_i` is 0. With `por_block_i` at 1 the request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| tick_i | input | 1 | Time-base tick; the counter advances in cycles where it is high |
| clear_i | input | 1 | Synchronous master clear, overrides all other inputs |
| por_req_i | input | 1 | Single-cycle power-on restart request |
| por_block_i | input | 1 | Masks the power-on request when high |
| sel_i | input | 2 | Stage select (bit 1, bit 0) |
| mode_i | input | 1 | 1 = repeating divider, 0 = one-shot |
| invert_i | input | 1 | Output phase after a restart |
| tmr_o | output | 1 | Registered timer output |
| run_o | output | 1 | Time-base enable, low during a restart |

## Verification
The hardest situation to reach is a one-shot output that has already fired and is then re-armed by a rising edge on the mode input. Reaching it needs hundreds of ticks, then a mode pulse placed at a count where the tap bit is low, so that clearing the hold state is visible at the output. The directed stimulus steps to exact counts for this, and to the half-period boundaries of every stage select. A seeded random phase then mixes tick gaps, rare mode and phase flips, select changes, and masked and unmasked power-on requests. Every output is compared against a cycle model kept in the bench.

// File: rtl/divt_pkg.sv
package divt_pkg;

    typedef struct packed {
        logic held;       // one-shot hold state
        logic mode_seen;  // previous-cycle copy of the mode input
        logic level;      // registered output level
    } ostate_t;

    localparam ostate_t OSTATE_CLEAR = '0;

endpackage

// File: rtl/divt_counter.sv
module divt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             restart_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/divt_tap_sel.sv
module divt_tap_sel #(
    parameter int CNT_W  = 16,
    parameter int STG_00 = 13,
    parameter int STG_01 = 8,
    parameter int STG_10 = 10,
    parameter int STG_11 = 16,
    localparam int IDX_W = $clog2(CNT_W)
) (
    input  logic [1:0]       sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             tap_o
);

    logic [IDX_W-1:0] idx;

    always_comb begin
        case (sel_i)
            2'b00:   idx = IDX_W'(STG_00 - 1);
            2'b01:   idx = IDX_W'(STG_01 - 1);
            2'b10:   idx = IDX_W'(STG_10 - 1);
            default: idx = IDX_W'(STG_11 - 1);
        endcase
    end

    assign tap_o = cnt_i[idx];

endmodule

// File: rtl/divt_out_stage.sv
module divt_out_stage
    import divt_pkg::*;
(
    input  logic clk_i,
    input  logic restart_i,
    input  logic mode_i,
    input  logic invert_i,
    input  logic tap_i,
    output logic level_o,
    output logic held_o,
    output logic mode_seen_o
);

    ostate_t st_d, st_q;
    logic    mode_rise;

    always_comb begin
        st_d      = st_q;
        mode_rise = mode_i & ~st_q.mode_seen;
        if (restart_i) begin
            st_d           = OSTATE_CLEAR;
            st_d.mode_seen = mode_i;
            st_d.level     = invert_i;
        end else begin
            if (mode_rise) begin
                st_d.held = 1'b0;
            end else if (!mode_i) begin
                st_d.held = st_q.held | tap_i;
            end
            st_d.mode_seen = mode_i;
            st_d.level     = (mode_i ? tap_i : st_d.held) ^ invert_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign level_o     = st_q.level;
    assign held_o      = st_q.held;
    assign mode_seen_o = st_q.mode_seen;

endmodule

// File: rtl/prog_divtimer.sv
module prog_divtimer #(
    parameter int CNT_W  = 16,
    parameter int STG_00 = 13,
    parameter int STG_01 = 8,
    parameter int STG_10 = 10,
    parameter int STG_11 = 16
) (
    input  logic       clk_i,
    input  logic       tick_i,
    input  logic       clear_i,
    input  logic       por_req_i,
    input  logic       por_block_i,
    input  logic [1:0] sel_i,
    input  logic       mode_i,
    input  logic       invert_i,
    output logic       tmr_o,
    output logic       run_o
);

    logic             restart;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             tap;
    logic             latch_q;
    logic             mode_q;

    // Master clear wins; power-on request only when not blocked
    assign restart = clear_i | (por_req_i & ~por_block_i);
    assign run_o   = ~restart;

    divt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .restart_i(restart),
        .tick_i   (tick_i),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d)
    );

    // Tap the next count so the output register lines up with the counter
    divt_tap_sel #(
        .CNT_W (CNT_W),
        .STG_00(STG_00),
        .STG_01(STG_01),
        .STG_10(STG_10),
        .STG_11(STG_11)
    ) u_tap (
        .sel_i(sel_i),
        .cnt_i(cnt_d),
        .tap_o(tap)
    );

    divt_out_stage u_out (
        .clk_i      (clk_i),
        .restart_i  (restart),
        .mode_i     (mode_i),
        .invert_i   (invert_i),
        .tap_i      (tap),
        .level_o    (tmr_o),
        .held_o     (latch_q),
        .mode_seen_o(mode_q)
    );

endmodule

// File: rtl/divt_checker.sv
module divt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             tick_i,
    input logic             clear_i,
    input logic             por_req_i,
    input logic             por_block_i,
    input logic             mode_i,
    input logic             invert_i,
    input logic             tmr_o,
    input logic             run_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic             latch_q,
    input logic             mode_q
);

    AST_CLEAR_LEVEL: assert property (@(posedge clk_i)
        clear_i |=> (tmr_o == $past(invert_i)));  // R1

    AST_RUN_OFF_IN_CLEAR: assert property (@(posedge clk_i)
        clear_i |-> !run_o);  // R2

    AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (clear_i)
        (!tick_i && !(por_req_i && !por_block_i)) |=> $stable(cnt_q));  // R3

    AST_ONESHOT_HELD: assert property (@(posedge clk_i) disable iff (clear_i)
        (!mode_i && latch_q && !(por_req_i && !por_block_i)) |=> (tmr_o != $past(invert_i)));  // R6

    AST_MODE_RISE_CLR: assert property (@(posedge clk_i) disable iff (clear_i)
        (mode_i && !mode_q) |=> !latch_q);  // R7

    AST_POR_MASKED: assert property (@(posedge clk_i) disable iff (clear_i)
        (por_req_i && por_block_i) |-> run_o);  // R9

    AST_POR_TAKEN: assert property (@(posedge clk_i)
        (por_req_i && !por_block_i) |=> (cnt_q == '0 && !latch_q));  // R9

endmodule

bind prog_divtimer divt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .tick_i     (tick_i),
    .clear_i    (clear_i),
    .por_req_i  (por_req_i),
    .por_block_i(por_block_i),
    .mode_i     (mode_i),
    .invert_i   (invert_i),
    .tmr_o      (tmr_o),
    .run_o      (run_o),
    .cnt_q      (cnt_q),
    .latch_q    (latch_q),
    .mode_q     (mode_q)
);

// File: tb/sim_prog_divtimer.sv
module sim_prog_divtimer;

    logic       clk = 1'b0;
    logic       tick, clr, por, blk, mode, inv;
    logic [1:0] sel;
    logic       tmr, run;

    always #4 clk = ~clk;

    prog_divtimer u0 (
        .clk_i      (clk),
        .tick_i     (tick),
        .clear_i    (clr),
        .por_req_i  (por),
        .por_block_i(blk),
        .sel_i      (sel),
        .mode_i     (mode),
        .invert_i   (inv),
        .tmr_o      (tmr),
        .run_o      (run)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;
    int unsigned m_cnt = 0;
    logic        m_held = 1'b0, m_mode = 1'b0, m_out = 1'b0;

    // R4: stage select to tap bit index
    function automatic int tap_of(input logic [1:0] s);
        case (s)
            2'b00:   return 12;
            2'b01:   return 7;
            2'b10:   return 9;
            default: return 15;
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic b, rise;
        if (clr | (por & ~blk)) begin
            m_cnt  = 0;
            m_held = 1'b0;
            m_mode = mode;
            m_out  = inv;
        end else begin
            rise = mode & ~m_mode;
            if (tick) m_cnt = (m_cnt + 1) & 32'hFFFF;
            b = m_cnt[tap_of(sel)];
            if (rise) m_held = 1'b0;
            else if (!mode) m_held = m_held | b;
            m_mode = mode;
            m_out  = (mode ? b : m_held) ^ inv;
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tmr, m_out, tag);
        chk(run, ~(clr | (por & ~blk)), "R2 run flag");
    endtask

    task automatic run_n(input int k, input string tag);
        repeat (k) cyc(tag);
    endtask

    task automatic do_restart();
        clr = 1'b1;
        cyc("R1");
        clr = 1'b0;
        chk(tmr, inv, "R1 level after clear");
    endtask

    initial begin
        logic [1:0] sv [3];
        int         hv [3];
        sv = '{2'b00, 2'b10, 2'b11};
        hv = '{4096, 512, 32768};
        void'($urandom(32'd20240611));
        tick = 1'b0; clr = 1'b1; por = 1'b0; blk = 1'b0;
        sel = 2'b01; mode = 1'b1; inv = 1'b0;
        cyc("R1");
        cyc("R1");
        chk(run, 1'b0, "R2 run low during clear");
        chk(tmr, 1'b0, "R1 reset level");
        clr = 1'b0;
        tick = 1'b1;

        // R5 divider n=8
        run_n(127, "R5");
        chk(tmr, 1'b0, "R5 before half period");
        cyc("R5");
        chk(tmr, 1'b1, "R5 at half period");
        run_n(128, "R5");
        chk(tmr, 1'b0, "R5 full period");

        // R3 tick gating at count 383
        run_n(127, "R3");
        tick = 1'b0;
        run_n(20, "R3");
        chk(tmr, 1'b0, "R3 no advance without tick");
        tick = 1'b1;
        cyc("R3");
        chk(tmr, 1'b1, "R3 tick resumes");

        // R4 remaining selects
        for (int k = 0; k < 3; k++) begin
            sel = sv[k];
            do_restart();
            run_n(hv[k] - 1, "R4");
            chk(tmr, 1'b0, "R4 tap low before boundary");
            cyc("R4");
            chk(tmr, 1'b1, "R4 tap high at boundary");
        end

        // R8 inverted phase
        sel = 2'b01;
        inv = 1'b1;
        do_restart();
        chk(tmr, 1'b1, "R8 inverted start level");
        run_n(128, "R8");
        chk(tmr, 1'b0, "R8 inverted wave");

        // R6 one-shot
        inv = 1'b0;
        mode = 1'b0;
        do_restart();
        run_n(127, "R6");
        chk(tmr, 1'b0, "R6 before firing");
        cyc("R6");
        chk(tmr, 1'b1, "R6 fires");
        run_n(200, "R6");
        chk(tmr, 1'b1, "R6 held after tap falls");

        // R7 mode rising edge clears hold (count 328 -> 330, tap low)
        mode = 1'b1;
        cyc("R7");
        mode = 1'b0;
        cyc("R7");
        chk(tmr, 1'b0, "R7 hold cleared by mode rise");
        run_n(54, "R7");
        chk(tmr, 1'b1, "R7 rearmed fires again");

        // R9 masked and honoured power-on requests
        blk = 1'b1;
        por = 1'b1;
        #1 chk(run, 1'b1, "R9 masked request keeps run");
        cyc("R9");
        por = 1'b0;
        blk = 1'b0;
        chk(tmr, 1'b1, "R9 masked request ignored");
        por = 1'b1;
        #1 chk(run, 1'b0, "R9 honoured request drops run");
        cyc("R9");
        por = 1'b0;
        chk(tmr, 1'b0, "R9 honoured request restarts");

        // Seeded random mix
        for (int i = 0; i < 20000; i++) begin
            tick = ($urandom % 3) != 0;
            clr  = ($urandom % 500) == 0;
            por  = ($urandom % 300) == 0;
            blk  = $urandom % 2;
            if (($urandom % 200) == 0) mode = ~mode;
            if (($urandom % 400) == 0) inv = ~inv;
            if (($urandom % 1000) == 0) sel = 2'($urandom % 4);
            cyc("R6 R7 random mix");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule